// File: doc/BRIEF.md
# Dual-Processor Optimistic-Lock Control Register

This block is a single 8-bit control register that two processors share: a host and a coprocessor. Each processor has its own read strobe, write strobe, write data bus and read data bus. The low bits of the register drive the coprocessor's control pins: reset, interrupt request, non-maskable interrupt and ready. One bit lifts the write protection on the upper 32 KiB of shared memory. Both processors can see the stored bits at all times, together with two failure bits, one for each processor.

A processor changes the register with a read-modify-write sequence. The register guards that sequence with optimistic locking. A read arms a per-processor "clean" flag. An accepted write from one processor disarms the other processor's flag. If a processor writes while its flag is disarmed, the register keeps its value and that processor's failure bit is set. Software tests the failure bit on its next read, and that read also clears the bit. Everything runs on one system clock. Each strobe is a pulse lasting one clock cycle.

Top module: `cpr_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the register holds 0x00. In that state `cop_reset_n`, `cop_irq_n`, `cop_nmi_n` and `cop_ready` are all 0, `upper_wp` is 1, and both read buses show 0x00.
- R2: The stored bits map to outputs as follows. Bit 0 drives `cop_reset_n`, bit 1 drives `cop_irq_n`, bit 2 drives `cop_nmi_n` and bit 3 drives `cop_ready`. `upper_wp` is the inverse of bit 4. Bit 5 is stored and read back but drives no pin.
- R3: Both read buses continuously show the same value. Bits 5:0 are the stored bits, bit 6 is the coprocessor failure flag and bit 7 is the host failure flag. Bits 7:6 of any write data are ignored.
- R4: A read strobe arms the reading processor's clean flag. The processor's next write is then accepted, provided no accepted write from the other processor came in between. The new bits 5:0 appear on the outputs one clock after the strobe.
- R5: An accepted write disarms the other processor's clean flag. The writer keeps its own armed flag, so it can write again without another read.
- R6: A write from a processor whose clean flag is disarmed leaves the register unchanged and sets that processor's failure flag.
- R7: A write with no read by that processor since reset is rejected as described in R6.
- R8: A read clears only the reader's own failure flag. Data sampled during the read strobe cycle still shows the flag as it was before the read.
- R9: If both processors write in the same cycle and the host write is accepted, the coprocessor write is rejected and sets the coprocessor failure flag. If the host write is rejected, the coprocessor write is judged by its own clean flag alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Host reset, active low, asynchronous |
| host_rd | input | 1 | Host read strobe, one-cycle pulse |
| host_wr | input | 1 | Host write strobe, one-cycle pulse |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host view of the register and failure flags |
| cop_rd | input | 1 | Coprocessor read strobe, one-cycle pulse |
| cop_wr | input | 1 | Coprocessor write strobe, one-cycle pulse |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_rdata | output | 8 | Coprocessor view of the register and failure flags |
| cop_reset_n | output | 1 | Coprocessor reset, active low |
| cop_irq_n | output | 1 | Coprocessor interrupt request, active low |
| cop_nmi_n | output | 1 | Coprocessor non-maskable interrupt, active low |
| cop_ready | output | 1 | Coprocessor ready; 0 halts it |
| upper_wp | output | 1 | Write protection for the upper half of shared memory |

## Verification
The bench first writes before any read. If a design treated the clean flag as armed after reset, it would accept that first write and release the coprocessor by accident. A second group of checks clears one processor's failure flag while the other processor's flag is still set. This exposes a design that clears both flags on any read, and a design that reports the flag only after clearing it. A third group issues simultaneous writes, once with the host's flag armed and once with it disarmed. A design with the wrong priority, or one that lets a rejected host write block the coprocessor, would store the wrong data or set the wrong failure bit. The last group writes 1s to bits 7:6 and checks that they cannot set the failure flags.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int REG_W   = 8;
  localparam int CTRL_W  = 6;
  localparam int NSIDE   = 2;
  localparam int SIDE_H  = 0;
  localparam int SIDE_C  = 1;

  localparam int B_RST   = 0;
  localparam int B_IRQ   = 1;
  localparam int B_NMI   = 2;
  localparam int B_RDY   = 3;
  localparam int B_WEN   = 4;
  localparam int B_FAILC = 6;
  localparam int B_FAILH = 7;

  // Status word seen by both processors.
  function automatic logic [REG_W-1:0] pack_status(
    input logic [CTRL_W-1:0] ctrl,
    input logic              fail_c,
    input logic              fail_h
  );
    logic [REG_W-1:0] s;
    s              = '0;
    s[CTRL_W-1:0]  = ctrl;
    s[B_FAILC]     = fail_c;
    s[B_FAILH]     = fail_h;
    return s;
  endfunction

  // Write arbitration: host first, coprocessor only if host not accepted.
  function automatic logic [NSIDE-1:0] arbitrate(
    input logic [NSIDE-1:0] wr,
    input logic [NSIDE-1:0] clean
  );
    logic [NSIDE-1:0] g;
    g[SIDE_H] = wr[SIDE_H] & clean[SIDE_H];
    g[SIDE_C] = wr[SIDE_C] & clean[SIDE_C] & ~g[SIDE_H];
    return g;
  endfunction
endpackage

// File: rtl/cpr_lock_side.sv
module cpr_lock_side (
  input  logic clk,
  input  logic rst_n,
  input  logic rd,
  input  logic wr,
  input  logic granted,
  input  logic peer_granted,
  output logic clean,
  output logic fail,
  output logic rejected
);
  logic clean_q, fail_q;
  logic clean_d, fail_d;

  assign rejected = wr & ~granted;

  always_comb begin
    clean_d = clean_q;
    if (peer_granted) clean_d = 1'b0;
    if (rd)           clean_d = 1'b1;
    fail_d = fail_q;
    if (rd)       fail_d = 1'b0;
    if (rejected) fail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean_q <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      clean_q <= clean_d;
      fail_q  <= fail_d;
    end
  end

  assign clean = clean_q;
  assign fail  = fail_q;

  AST_READ_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> clean); // R4
  AST_PEER_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    peer_granted && !rd |=> !clean); // R5
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |=> fail); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !wr |=> !fail); // R8
  AST_GRANT_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    granted |-> clean); // R6
endmodule

// File: rtl/cpr_ctrl_reg.sv
module cpr_ctrl_reg
  import cpr_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSIDE-1:0] gnt,
  input  logic [W-1:0]     wdata_h,
  input  logic [W-1:0]     wdata_c,
  output logic [W-1:0]     ctrl
);
  logic [W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (gnt[SIDE_H])      ctrl_d = wdata_h;
    else if (gnt[SIDE_C]) ctrl_d = wdata_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  AST_RESET_HALTS: assert property (@(posedge clk)
    !rst_n |=> ctrl_q == '0); // R1
  AST_HOLD_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt == '0 |=> $stable(ctrl_q)); // R6
  AST_HOST_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[SIDE_H] |=> ctrl_q == $past(wdata_h)); // R4
  AST_COP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[SIDE_C] && !gnt[SIDE_H] |=> ctrl_q == $past(wdata_c)); // R9
endmodule

// File: rtl/cpr_lock_ctrl.sv
module cpr_lock_ctrl
  import cpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             cop_rd,
  input  logic             cop_wr,
  input  logic [REG_W-1:0] cop_wdata,
  output logic [REG_W-1:0] cop_rdata,
  output logic             cop_reset_n,
  output logic             cop_irq_n,
  output logic             cop_nmi_n,
  output logic             cop_ready,
  output logic             upper_wp
);
  logic [NSIDE-1:0]  rd_v, wr_v, gnt_v, clean_v, fail_v, rej_v;
  logic [CTRL_W-1:0] ctrl;
  logic [REG_W-1:0]  status;

  assign rd_v[SIDE_H] = host_rd;
  assign rd_v[SIDE_C] = cop_rd;
  assign wr_v[SIDE_H] = host_wr;
  assign wr_v[SIDE_C] = cop_wr;

  assign gnt_v = arbitrate(wr_v, clean_v);

  for (genvar i = 0; i < NSIDE; i++) begin : g_side
    cpr_lock_side side_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd           (rd_v[i]),
      .wr           (wr_v[i]),
      .granted      (gnt_v[i]),
      .peer_granted (gnt_v[NSIDE-1-i]),
      .clean        (clean_v[i]),
      .fail         (fail_v[i]),
      .rejected     (rej_v[i])
    );
  end

  cpr_ctrl_reg #(.W(CTRL_W)) reg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .gnt     (gnt_v),
    .wdata_h (host_wdata[CTRL_W-1:0]),
    .wdata_c (cop_wdata[CTRL_W-1:0]),
    .ctrl    (ctrl)
  );

  assign status      = pack_status(ctrl, fail_v[SIDE_C], fail_v[SIDE_H]);
  assign host_rdata  = status;
  assign cop_rdata   = status;

  assign cop_reset_n = ctrl[B_RST];
  assign cop_irq_n   = ctrl[B_IRQ];
  assign cop_nmi_n   = ctrl[B_NMI];
  assign cop_ready   = ctrl[B_RDY];
  assign upper_wp    = ~ctrl[B_WEN];

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_v)); // R9
  AST_HOST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_v[SIDE_H] && cop_wr |=> fail_v[SIDE_C]); // R9
  AST_WIN_DISARMS_COP: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_v[SIDE_H] && !cop_rd |=> !clean_v[SIDE_C]); // R5
  AST_WRITER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_v[SIDE_H] |=> clean_v[SIDE_H]); // R5
  AST_VIEWS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata == cop_rdata); // R3
endmodule

// File: tb/cpr_lock_ctrl_tb_top.sv
module cpr_lock_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_rd = 1'b0, host_wr = 1'b0, cop_rd = 1'b0, cop_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00, cop_wdata = 8'h00;
  logic [7:0] host_rdata, cop_rdata;
  logic       cop_reset_n, cop_irq_n, cop_nmi_n, cop_ready, upper_wp;

  int n_chk = 0;
  int n_bad = 0;

  // Reference state kept from the requirements.
  logic [5:0] m_ctrl = 6'h00;
  logic       m_clean_h = 1'b0, m_clean_c = 1'b0, m_fail_h = 1'b0, m_fail_c = 1'b0;
  logic [7:0] rd_snap_h, rd_snap_c;

  always #4 clk = ~clk;

  cpr_lock_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cop_rd(cop_rd), .cop_wr(cop_wr), .cop_wdata(cop_wdata), .cop_rdata(cop_rdata),
    .cop_reset_n(cop_reset_n), .cop_irq_n(cop_irq_n), .cop_nmi_n(cop_nmi_n),
    .cop_ready(cop_ready), .upper_wp(upper_wp)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {m_fail_h, m_fail_c, m_ctrl};
  endfunction

  // R2/R3: pins and both read buses against the reference state.
  task automatic check_all(input string req);
    check({req, " host_rdata"}, host_rdata, m_status());
    check({req, " cop_rdata"},  cop_rdata,  m_status());
    check({req, " pins"}, {3'b0, upper_wp, cop_ready, cop_nmi_n, cop_irq_n, cop_reset_n},
          {3'b0, ~m_ctrl[4], m_ctrl[3], m_ctrl[2], m_ctrl[1], m_ctrl[0]});
  endtask

  // One strobe cycle; reference updated per R4..R9.
  task automatic step(input logic hrd, input logic hwr, input logic [7:0] hd,
                      input logic crd, input logic cwr, input logic [7:0] cd);
    logic gh, gc;
    @(negedge clk);
    host_rd = hrd; host_wr = hwr; host_wdata = hd;
    cop_rd = crd;  cop_wr = cwr;  cop_wdata = cd;
    #1;
    rd_snap_h = host_rdata;
    rd_snap_c = cop_rdata;
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0; cop_rd = 1'b0; cop_wr = 1'b0;
    gh = hwr & m_clean_h;
    gc = cwr & m_clean_c & ~gh;
    if (gh) m_ctrl = hd[5:0];
    else if (gc) m_ctrl = cd[5:0];
    m_fail_h  = (hwr & ~gh) | (m_fail_h & ~hrd);
    m_fail_c  = (cwr & ~gc) | (m_fail_c & ~crd);
    m_clean_h = hrd | (m_clean_h & ~gc);
    m_clean_c = crd | (m_clean_c & ~gh);
    #1;
  endtask

  task automatic t_reset();
    check_all("R1 reset");
    check("R1 wp set", {7'b0, upper_wp}, 8'h01);
  endtask

  task automatic t_write_before_read();
    step(0, 1, 8'h1F, 0, 0, 8'h00);
    check_all("R7 unread write");
    check("R6 host fail bit", host_rdata, 8'h80);
    step(1, 0, 8'h00, 0, 0, 8'h00);
    check("R8 read shows pre-clear", rd_snap_h, 8'h80);
    check("R8 cleared after read", host_rdata, 8'h00);
  endtask

  task automatic t_rmw_ok();
    step(0, 1, 8'h1F, 0, 0, 8'h00);
    check_all("R4 accepted write");
    check("R2 released pins", {3'b0, upper_wp, cop_ready, cop_nmi_n, cop_irq_n, cop_reset_n}, 8'h0F);
    step(0, 1, 8'h2B, 0, 0, 8'h00);
    check_all("R5 writer keeps clean");
    check("R2 bit5 stored, nmi low", host_rdata, 8'h2B);
  endtask

  task automatic t_conflict();
    step(1, 0, 8'h00, 1, 0, 8'h00);
    step(0, 0, 8'h00, 0, 1, 8'hFF);
    check("R3 bits7:6 ignored", cop_rdata, 8'h3F);
    step(0, 1, 8'h00, 0, 0, 8'h00);
    check_all("R5 host disarmed");
    check("R6 host blocked", host_rdata, 8'hBF);
    step(0, 0, 8'h00, 1, 0, 8'h00);
    check("R8 other flag kept", host_rdata, 8'hBF);
    step(1, 0, 8'h00, 0, 0, 8'h00);
    check("R8 host read snapshot", rd_snap_h, 8'hBF);
    check_all("R8 host flag cleared");
  endtask

  task automatic t_simul_host_wins();
    step(1, 0, 8'h00, 1, 0, 8'h00);
    step(0, 1, 8'h09, 0, 1, 8'h15);
    check_all("R9 host priority");
    check("R9 cop fail", cop_rdata, 8'h49);
    step(0, 0, 8'h00, 1, 0, 8'h00);
    check("R8 cop cleared", cop_rdata, 8'h09);
  endtask

  task automatic t_simul_cop_alone();
    step(1, 0, 8'h00, 1, 0, 8'h00);
    step(0, 0, 8'h00, 0, 1, 8'h0B);
    step(0, 1, 8'h01, 0, 1, 8'h0F);
    check_all("R9 host rejected cop judged alone");
    check("R9 cop wins", cop_rdata, 8'h8F);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    m_ctrl = 6'h00; m_clean_h = 0; m_clean_c = 0; m_fail_h = 0; m_fail_c = 0;
    check_all("R1 re-reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 8'h00, 0, 1, 8'h0F);
    check_all("R7 cop write after reset");
    check("R7 cop fail", cop_rdata, 8'h40);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_before_read();
    t_rmw_ok();
    t_conflict();
    t_simul_host_wins();
    t_simul_cop_alone();
    t_reset_again();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule